// File: doc/BRIEF.md
# Performance monitor counter group

This block is a group of event counters that watches an I/O address-translation unit. A small vector of event pulses comes in from the translation logic, together with the stream identifier of the transaction each pulse belongs to. Software selects one event number for each counter and gives it a stream filter. Software can also enable or disable a counter and preload its value. When a counter steps past all ones it wraps to zero and sets a sticky overflow bit. An interrupt line is driven while any overflowed counter also has its interrupt enabled and the interrupt gate is open.

Software reaches the block through a plain 32-bit register bus with no wait states:

- A write is taken on the rising clock edge on which `bus_we` is high.
- Read data is combinational from `bus_addr`.

Counter enable, interrupt enable and overflow status each have a pair of registers, one where a written 1 sets a bit and one where a written 1 clears it. Software can also read, at fixed addresses:

- a configuration word giving the counter count, the counter width and the filter style;
- a bitmap of the supported event numbers.

The parameter `GLOBAL_FLT` picks between two filter styles. In one, each counter uses its own filter. In the other, the filter of counter 0 governs every counter. At most 32 counters are supported.

Top module: `pmu_counter_group`

## Requirements
- R1: After reset the following all read zero and `irq` is low: every counter, the enable sets, the overflow status, the global enable (0xE04), the interrupt gate (0xE50), each event register and each stream register.
- R2: A counter rises by exactly one for each rising edge on which all of these hold:
  - its selected event input is high;
  - its stream filter passes;
  - its enable bit is set;
  - bit 0 of 0xE04 is set.

  Otherwise the counter holds its value.
- R3: Counter enable is set through 0xC00 and cleared through 0xC20. Interrupt enable is set through 0xC40 and cleared through 0xC60. In each case a 1 in bit n acts on counter n and a 0 leaves that bit unchanged. Both addresses of a pair read back the current enable bits.
- R4: With counters of 32 bits or fewer, counter n is read and written at byte offset 4n. Wider counters use offset 8n, with the high word at 8n+4. A write to a counter takes priority over an increment in the same cycle.
- R5: On a wrap from all ones to zero, overflow bit n is set and stays set. The overflow bits read at 0xCC0. Writing a 1 to bit n of 0xC80 clears bit n and writing a 0 has no effect. A wrap in the same cycle as a clear leaves the bit set.
- R6: `irq` is high exactly when bit 0 of 0xE50 is set and some counter has both its overflow bit and its interrupt-enable bit set.
- R7: The event register of counter n is at 0x400+4n, with the event number in bits 15:0 and the span flag in bit 29. The stream register of counter n is at 0xA00+4n and holds `SID_W` bits. With the span flag clear, an event counts only when `ev_sid` equals the stream register.
- R8: With the span flag set, the stream register is read from its low bit upwards. The trailing ones and the first zero above them are don't-care positions. All higher bits must equal `ev_sid`. A register of all ones therefore passes every stream. For example, 0x42 passes streams 0x42 and 0x43.
- R9: The word at 0xE00 reads as follows:
  - bits 5:0 hold `NUM_CTR`-1;
  - bits 13:8 hold `CTR_W`-1;
  - bit 23 holds `GLOBAL_FLT`;
  - bits 20, 21 and all other bits read zero.
- R10: The supported-event bitmap is at 0xE20, 0xE24, 0xE28 and 0xE2C. Bit b of the word at 0xE20+4k stands for event 32k+b, and that bit is 1 exactly when 32k+b is below `EVT_IN`.
- R11: Reads of unimplemented offsets return zero. A counter whose event number is `EVT_IN` or above never counts.
- R12: With `GLOBAL_FLT` set to 1, every counter is filtered by the span flag and stream register of counter 0. The counters' own stream registers then have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ev_in | input | EVT_IN | Event pulses, bit e is event number e |
| ev_sid | input | SID_W | Stream identifier qualifying the current event pulses |
| irq | output | 1 | Level interrupt |

## Verification
Several results follow from one write or one event cycle:

| Result | When it is due |
|--------|----------------|
| Written register value | Visible in the cycle after the write edge |
| Counter increment | On the edge that samples the event |
| Overflow bit after a wrap | On the same edge as the wrap |
| `irq` | Follows the registers combinationally |

The bench drives every input on the falling edge and lets the next rising edge take it. It then sets the read address at a later falling edge and samples `bus_rdata` and `irq` one nanosecond later, so every read lies a whole cycle after the edge that produced it. The two same-cycle priority cases apply both stimuli in a single cycle and then read the result. The cases are a counter write against an increment, and an overflow clear against a wrap.

// File: rtl/pmu_pkg.sv
// Package: register offsets and shared types of the counter group.
// Assumes a byte-addressed bus with word-aligned 32-bit accesses.
package pmu_pkg;
    localparam int OFS_EVT     = 'h400;
    localparam int OFS_SMR     = 'hA00;
    localparam int OFS_CEN_SET = 'hC00;
    localparam int OFS_CEN_CLR = 'hC20;
    localparam int OFS_IEN_SET = 'hC40;
    localparam int OFS_IEN_CLR = 'hC60;
    localparam int OFS_OVF_CLR = 'hC80;
    localparam int OFS_OVF_RD  = 'hCC0;
    localparam int OFS_CFG     = 'hE00;
    localparam int OFS_CTRL    = 'hE04;
    localparam int OFS_SUPP    = 'hE20;
    localparam int OFS_IRQCTL  = 'hE50;
    localparam int SUPP_WORDS  = 4;
    localparam int SPAN_BIT    = 29;

    // Per-counter event selection held in the event register.
    typedef struct packed {
        logic        span;
        logic [15:0] evnum;
    } evt_cfg_t;
endpackage

// File: rtl/pmu_setclr_reg.sv
// Bit vector with separate set and clear masks, one bit per counter.
// SET_WINS picks the outcome when a bit is set and cleared in one cycle.
module pmu_setclr_reg #(
    parameter int W        = 4,
    parameter bit SET_WINS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    output logic [W-1:0] q
);
    // Update the vector from the masks.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (SET_WINS) q <= (q & ~clr_m) | set_m;
        else               q <= (q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/pmu_stream_filter.sv
// Stream-identifier match for one counter.
// With span clear the match is exact. With span set, the trailing ones of the
// pattern and the first zero above them are ignored.
module pmu_stream_filter #(
    parameter int SID_W = 16
) (
    input  logic [SID_W-1:0] pattern,
    input  logic             span,
    input  logic [SID_W-1:0] sid,
    output logic             pass
);
    logic [SID_W-1:0] care;

    // Bits that must match: all of them, or those above the span marker.
    always_comb begin
        care = span ? ~(pattern ^ (pattern + 1'b1)) : '1;
        pass = ((sid ^ pattern) & care) == '0;
    end
endmodule

// File: rtl/pmu_event_counter.sv
// One event counter with software load and a wrap flag.
// A load takes priority over an increment; a loaded cycle never reports a wrap.
module pmu_event_counter #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTR_W-1:0] wval,
    input  logic             inc,
    output logic [CTR_W-1:0] cnt,
    output logic             wrap
);
    // Load, count or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (wr)  cnt <= wval;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // Flag the step from all ones back to zero.
    assign wrap = inc && !wr && (cnt == '1);
endmodule

// File: rtl/pmu_counter_group.sv
// Memory-mapped group of event counters with stream filtering, sticky overflow
// and a gated level interrupt.
// Assumes NUM_CTR <= 32, CTR_W <= 64, and reads combinational from bus_addr.
module pmu_counter_group
    import pmu_pkg::*;
#(
    parameter int NUM_CTR    = 4,
    parameter int CTR_W      = 32,
    parameter int EVT_IN     = 8,
    parameter int SID_W      = 16,
    parameter int ADDR_W     = 12,
    parameter bit GLOBAL_FLT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [EVT_IN-1:0] ev_in,
    input  logic [SID_W-1:0]  ev_sid,
    output logic              irq
);
    localparam int STRIDE = (CTR_W > 32) ? 8 : 4;
    localparam logic [31:0] CFG_WORD = (32'(GLOBAL_FLT) << 23)
                                     | (32'(CTR_W - 1) << 8)
                                     | 32'(NUM_CTR - 1);

    evt_cfg_t                           cfg_q [NUM_CTR];
    logic [SID_W-1:0]                   smr_q [NUM_CTR];
    logic                               glob_en_q, irq_en_q;
    logic [NUM_CTR-1:0]                 cnten_q, inten_q, ovf_q;
    logic [NUM_CTR-1:0]                 cen_set, cen_clr, ien_set, ien_clr, ovf_clr_m;
    logic [NUM_CTR-1:0]                 cnt_wr, cnt_inc, cnt_wrap, wr_lo, wr_hi;
    logic [NUM_CTR-1:0][CTR_W-1:0]      cnt_all;

    // Decode the bus address for the mask registers and counter words.
    always_comb begin
        cen_set   = (bus_we && bus_addr == ADDR_W'(OFS_CEN_SET)) ? bus_wdata[NUM_CTR-1:0] : '0;
        cen_clr   = (bus_we && bus_addr == ADDR_W'(OFS_CEN_CLR)) ? bus_wdata[NUM_CTR-1:0] : '0;
        ien_set   = (bus_we && bus_addr == ADDR_W'(OFS_IEN_SET)) ? bus_wdata[NUM_CTR-1:0] : '0;
        ien_clr   = (bus_we && bus_addr == ADDR_W'(OFS_IEN_CLR)) ? bus_wdata[NUM_CTR-1:0] : '0;
        ovf_clr_m = (bus_we && bus_addr == ADDR_W'(OFS_OVF_CLR)) ? bus_wdata[NUM_CTR-1:0] : '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            wr_lo[i] = bus_we && bus_addr == ADDR_W'(i * STRIDE);
            wr_hi[i] = bus_we && (CTR_W > 32) && bus_addr == ADDR_W'(i * STRIDE + 4);
        end
    end

    // Hold event selection, stream patterns and the two global bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en_q <= 1'b0;
            irq_en_q  <= 1'b0;
            for (int i = 0; i < NUM_CTR; i++) begin
                cfg_q[i] <= '0;
                smr_q[i] <= '0;
            end
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_CTRL))   glob_en_q <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFS_IRQCTL)) irq_en_q  <= bus_wdata[0];
            for (int i = 0; i < NUM_CTR; i++) begin
                if (bus_addr == ADDR_W'(OFS_EVT + 4 * i))
                    cfg_q[i] <= '{span: bus_wdata[SPAN_BIT], evnum: bus_wdata[15:0]};
                if (bus_addr == ADDR_W'(OFS_SMR + 4 * i))
                    smr_q[i] <= bus_wdata[SID_W-1:0];
            end
        end
    end

    pmu_setclr_reg #(.W(NUM_CTR), .SET_WINS(1'b0)) u_cnten (
        .clk(clk), .rst_n(rst_n), .set_m(cen_set), .clr_m(cen_clr), .q(cnten_q));
    pmu_setclr_reg #(.W(NUM_CTR), .SET_WINS(1'b0)) u_inten (
        .clk(clk), .rst_n(rst_n), .set_m(ien_set), .clr_m(ien_clr), .q(inten_q));
    pmu_setclr_reg #(.W(NUM_CTR), .SET_WINS(1'b1)) u_ovf (
        .clk(clk), .rst_n(rst_n), .set_m(cnt_wrap), .clr_m(ovf_clr_m), .q(ovf_q));

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic [CTR_W-1:0] wval;
        logic             ev_sel, pass;
        localparam int FSRC = GLOBAL_FLT ? 0 : g;

        if (CTR_W > 32) begin : g_wide
            // Merge a written word with the untouched half of the counter.
            assign wval = wr_lo[g] ? {cnt_all[g][CTR_W-1:32], bus_wdata}
                                   : {bus_wdata[CTR_W-33:0], cnt_all[g][31:0]};
        end else begin : g_narrow
            assign wval = bus_wdata[CTR_W-1:0];
        end
        assign cnt_wr[g] = wr_lo[g] | wr_hi[g];

        // Pick the event input named by the event number; none above EVT_IN-1.
        always_comb begin
            ev_sel = 1'b0;
            for (int e = 0; e < EVT_IN; e++)
                if (cfg_q[g].evnum == 16'(e)) ev_sel = ev_in[e];
        end

        pmu_stream_filter #(.SID_W(SID_W)) u_flt (
            .pattern(smr_q[FSRC]), .span(cfg_q[FSRC].span), .sid(ev_sid), .pass(pass));

        assign cnt_inc[g] = ev_sel && pass && cnten_q[g] && glob_en_q;

        pmu_event_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .wr(cnt_wr[g]), .wval(wval),
            .inc(cnt_inc[g]), .cnt(cnt_all[g]), .wrap(cnt_wrap[g]));
    end

    // Read multiplexer; unknown offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CFG))    bus_rdata = CFG_WORD;
        if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata = {31'b0, glob_en_q};
        if (bus_addr == ADDR_W'(OFS_IRQCTL)) bus_rdata = {31'b0, irq_en_q};
        if (bus_addr == ADDR_W'(OFS_CEN_SET) || bus_addr == ADDR_W'(OFS_CEN_CLR))
            bus_rdata = 32'(cnten_q);
        if (bus_addr == ADDR_W'(OFS_IEN_SET) || bus_addr == ADDR_W'(OFS_IEN_CLR))
            bus_rdata = 32'(inten_q);
        if (bus_addr == ADDR_W'(OFS_OVF_RD)) bus_rdata = 32'(ovf_q);
        for (int k = 0; k < SUPP_WORDS; k++)
            if (bus_addr == ADDR_W'(OFS_SUPP + 4 * k))
                for (int b = 0; b < 32; b++)
                    bus_rdata[b] = (k * 32 + b) < EVT_IN;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (bus_addr == ADDR_W'(i * STRIDE)) bus_rdata = 32'(cnt_all[i]);
            if (CTR_W > 32 && bus_addr == ADDR_W'(i * STRIDE + 4))
                bus_rdata = 32'(64'(cnt_all[i]) >> 32);
            if (bus_addr == ADDR_W'(OFS_EVT + 4 * i))
                bus_rdata = (32'(cfg_q[i].span) << SPAN_BIT) | 32'(cfg_q[i].evnum);
            if (bus_addr == ADDR_W'(OFS_SMR + 4 * i)) bus_rdata = 32'(smr_q[i]);
        end
    end

    // Level interrupt from enabled overflows behind the gate.
    assign irq = irq_en_q && |(ovf_q & inten_q);
endmodule

// File: rtl/pmu_counter_group_chk.sv
// Checker for the counter group: counter stepping, overflow stickiness and
// interrupt gating. Attached to every instance of the top by the bind below.
module pmu_counter_group_chk #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all,
    input logic [NUM_CTR-1:0]            cnt_wr,
    input logic [NUM_CTR-1:0]            cnten_q,
    input logic [NUM_CTR-1:0]            inten_q,
    input logic [NUM_CTR-1:0]            ovf_q,
    input logic [NUM_CTR-1:0]            ovf_clr_m,
    input logic                          glob_en_q,
    input logic                          irq_en_q,
    input logic                          irq
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> cnt_all == '0 && ovf_q == '0); // R1
    AST_IRQ_GATED:  assert property (@(posedge clk) disable iff (!rst_n) irq |-> irq_en_q); // R6
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (ovf_q & inten_q) != '0); // R6

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cnt_wr[g]) |-> (cnt_all[g] == $past(cnt_all[g]) || cnt_all[g] == $past(cnt_all[g]) + 1'b1)); // R2
        AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(cnt_wr[g]) && !$past(glob_en_q && cnten_q[g])) |-> $stable(cnt_all[g])); // R2
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ovf_q[g]) && !$past(ovf_clr_m[g])) |-> ovf_q[g]); // R5
        AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(cnt_wr[g]) && $past(cnt_all[g]) == '1 && cnt_all[g] == '0) |-> ovf_q[g]); // R5
    end
endmodule

bind pmu_counter_group pmu_counter_group_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_all(cnt_all), .cnt_wr(cnt_wr), .cnten_q(cnten_q),
    .inten_q(inten_q), .ovf_q(ovf_q), .ovf_clr_m(ovf_clr_m), .glob_en_q(glob_en_q),
    .irq_en_q(irq_en_q), .irq(irq));

// File: tb/tb_pmu_counter_group.sv
// Bench: a table of filter vectors walked by one loop, then directed tests.
// Inputs change on the falling edge; outputs are sampled 1 ns after a falling edge.
module tb_pmu_counter_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata2;
    logic [7:0]  ev_in = '0;
    logic [15:0] ev_sid = '0;
    logic        irq, irq2;
    int          nchk = 0, nerr = 0;
    bit          done = 1'b0;
    logic [31:0] v, v2;

    always #5 clk = ~clk;

    pmu_counter_group dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .ev_in(ev_in), .ev_sid(ev_sid), .irq(irq));

    pmu_counter_group #(.GLOBAL_FLT(1'b1)) dut2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata2), .ev_in(ev_in), .ev_sid(ev_sid), .irq(irq2));

    // Filter vectors: span, pattern, stream, pulses, expected count.
    localparam int NV = 9;
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 16'h0042, 16'h0042, 16'd3, 16'd3},
        {1'b0, 16'h0042, 16'h0043, 16'd3, 16'd0},
        {1'b1, 16'h0042, 16'h0043, 16'd4, 16'd4},
        {1'b1, 16'h0042, 16'h0044, 16'd4, 16'd0},
        {1'b1, 16'h0041, 16'h0040, 16'd2, 16'd2},
        {1'b1, 16'h0041, 16'h0044, 16'd2, 16'd0},
        {1'b1, 16'hFFFF, 16'h1234, 16'd5, 16'd5},
        {1'b0, 16'hFFFF, 16'h1234, 16'd5, 16'd0},
        {1'b1, 16'h00FF, 16'h00A5, 16'd2, 16'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk); addr = a; #1; v = rdata; v2 = rdata2;
    endtask

    task automatic pulse(input logic [7:0] m, input logic [15:0] sid, input int n);
        @(negedge clk); ev_in = m; ev_sid = sid;
        repeat (n) @(negedge clk);
        ev_in = '0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000); chk("R1 counter0", v, 0);
        rd(12'hC00); chk("R1 enables", v, 0);
        rd(12'hCC0); chk("R1 overflow", v, 0);
        rd(12'hE04); chk("R1 control", v, 0);
        rd(12'h400); chk("R1 event reg", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R9 configuration word, R12 filter-style bit
        rd(12'hE00); chk("R9 config", v, 32'h0000_1F03);
        chk("R12 config global", v2, 32'h0080_1F03);
        // R10 supported-event bitmap
        rd(12'hE20); chk("R10 events 0-31", v, 32'h0000_00FF);
        rd(12'hE24); chk("R10 events 32-63", v, 0);
        rd(12'hE28); chk("R10 events 64-95", v, 0);
        // R11 unimplemented offsets
        rd(12'hC04); chk("R11 hole C04", v, 0);
        rd(12'h7F0); chk("R11 hole 7F0", v, 0);

        // R3 set/clear pairs
        wr(12'hC00, 32'h5); rd(12'hC00); chk("R3 set", v, 32'h5);
        wr(12'hC00, 32'h2); rd(12'hC00); chk("R3 zero bits keep", v, 32'h7);
        wr(12'hC20, 32'h1); rd(12'hC20); chk("R3 clear", v, 32'h6);
        wr(12'hC20, 32'hF);
        wr(12'hC40, 32'h3); rd(12'hC60); chk("R3 int set", v, 32'h3);
        wr(12'hC60, 32'h1); rd(12'hC40); chk("R3 int clear", v, 32'h2);
        wr(12'hC60, 32'hF);

        // R2 counting qualifiers
        wr(12'h400, 32'h2000_0001); wr(12'hA00, 32'hFFFF);
        wr(12'h000, 0); wr(12'hC00, 32'h1);
        pulse(8'h02, 16'h0, 3); rd(12'h000); chk("R2 global off", v, 0);
        wr(12'hE04, 32'h1);
        pulse(8'h02, 16'h0, 3); rd(12'h000); chk("R2 counts", v, 3);
        pulse(8'h01, 16'h0, 3); rd(12'h000); chk("R2 other event", v, 3);
        wr(12'hC20, 32'h1);
        pulse(8'h02, 16'h0, 2); rd(12'h000); chk("R2 counter off", v, 3);

        // R4 preload, readback, write priority
        wr(12'h004, 32'h1234_5678); rd(12'h004); chk("R4 preload", v, 32'h1234_5678);
        wr(12'hC00, 32'h1);
        @(negedge clk); addr = 12'h000; we = 1'b1; wdata = 32'd100; ev_in = 8'h02;
        @(negedge clk); we = 1'b0; ev_in = '0;
        rd(12'h000); chk("R4 write beats increment", v, 32'd100);
        rd(12'h400); chk("R7 event readback", v, 32'h2000_0001);

        // R7/R8 filter table on counter 2, event 3
        wr(12'hC00, 32'h4);
        for (int i = 0; i < NV; i++) begin
            wr(12'h408, (32'(VEC[i][64]) << 29) | 32'h3);
            wr(12'hA08, 32'(VEC[i][63:48]));
            wr(12'h008, 0);
            pulse(8'h08, VEC[i][47:32], int'(VEC[i][31:16]));
            rd(12'h008);
            chk($sformatf("R7/R8 vector %0d", i), v, 32'(VEC[i][15:0]));
        end

        // R11 event number beyond the inputs
        wr(12'h40C, 32'h2000_0008); wr(12'hA0C, 32'hFFFF);
        wr(12'h00C, 0); wr(12'hC00, 32'h8);
        pulse(8'hFF, 16'h0, 4); rd(12'h00C); chk("R11 event 8", v, 0);

        // R12 global filter versus own filter on counter 1
        wr(12'h400, 32'h5); wr(12'hA00, 32'h5);
        wr(12'h404, 32'h5); wr(12'hA04, 32'h9);
        wr(12'h004, 0); wr(12'hC00, 32'h2);
        pulse(8'h20, 16'h5, 3); rd(12'h004);
        chk("R7 own filter blocks", v, 0);
        chk("R12 global filter passes", v2, 3);

        // R5/R6 wrap, overflow, interrupt
        wr(12'hC20, 32'hF); wr(12'hC80, 32'hF);
        wr(12'h400, 32'h2000_0001); wr(12'hA00, 32'hFFFF);
        wr(12'h000, 32'hFFFF_FFFE); wr(12'hC00, 32'h1);
        pulse(8'h02, 16'h0, 2);
        rd(12'h000); chk("R5 wrapped", v, 0);
        rd(12'hCC0); chk("R5 overflow set", v, 32'h1);
        chk("R6 no int enable", 32'(irq), 0);
        wr(12'hC40, 32'h1); rd(12'hCC0); chk("R6 gate closed", 32'(irq), 0);
        wr(12'hE50, 32'h1); rd(12'hCC0); chk("R6 irq high", 32'(irq), 1);
        wr(12'hC80, 32'h0); rd(12'hCC0); chk("R5 zero clear ignored", v, 32'h1);
        wr(12'hC80, 32'h1); rd(12'hCC0); chk("R5 cleared", v, 0);
        chk("R6 irq low", 32'(irq), 0);
        wr(12'h000, 32'hFFFF_FFFF);
        @(negedge clk); addr = 12'hC80; we = 1'b1; wdata = 32'h1; ev_in = 8'h02;
        @(negedge clk); we = 1'b0; ev_in = '0;
        rd(12'hCC0); chk("R5 wrap beats clear", v, 32'h1);
        chk("R6 irq again", 32'(irq), 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule